// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address of every beat of a short, fixed-length burst. A load pulse captures a complete external address. Each later advance pulse then moves only the low offset field, which is two bits wide by default, to the next beat. The upper address bits keep the value captured at load for the whole burst. A beat index output tells the surrounding controller which beat is current.

A static order input selects between two stepping rules. In interleaved order the offset is the start offset XORed with a binary beat count. In linear order the offset counts up by one from the start and wraps at the burst length. The order input is active high and should be tied high when unused, which makes interleaved order the default.

The advance input is active low. While it is high, the current address and beat are held, so wait states can be inserted anywhere in the burst. Address strobes and array access are decoded outside this block.

Top module: `bseq_burst_addr`

## Requirements
- R1: On a clock edge with `load_i` high, `addr_o` becomes `addr_i` and `beat_o` becomes 0 from the following cycle.
- R2: On an edge with `load_i` low, bits `addr_o[ADDR_W-1:2]` keep their value.
- R3: With `interleave_i` high (interleaved order, the default when tied high), `addr_o[1:0]` equals the start offset XOR `beat_o`. From start 01 the sequence is 01,00,11,10. From start 10 it is 10,11,00,01.
- R4: With `interleave_i` low (linear order), `addr_o[1:0]` equals (start offset + `beat_o`) mod 4. From start 11 the sequence is 11,00,01,10.
- R5: On an edge with `load_i` high, `adv_ni` is ignored. The beat restarts at 0 even when the load arrives in the middle of a burst with advance low.
- R6: On an edge with `load_i` low and `adv_ni` high, `beat_o` and `addr_o` stay unchanged.
- R7: On an edge with `load_i` low and `adv_ni` low, `beat_o` increments. An advance from beat 3 wraps to beat 0, which puts the start offset back on `addr_o[1:0]`.
- R8: While `rst_ni` is low, `addr_o` and `beat_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Capture `addr_i` and restart the burst |
| adv_ni | input | 1 | Advance to next beat, active low; high inserts a wait state |
| interleave_i | input | 1 | Order select: 1 interleaved (XOR), 0 linear; tie high by default |
| addr_i | input | ADDR_W | External start address |
| addr_o | output | ADDR_W | Address of the current beat |
| beat_o | output | 2 | Index of the current beat |

## Verification
Both orders are swept with every start offset. Each burst gets a fresh random upper address, and a random number of hold cycles is inserted before each advance. Six advances per burst carry the sequence across the wrap, which separates a correct modulo wrap from a counter that saturates or reloads. Because the XOR and add rules agree at start offset 00 and at beat 0, the nonzero start offsets are the ones that tell the two orders apart. A load issued mid-burst with advance held low shows that the beat restarts rather than stepping.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_order_e;
endpackage

// File: rtl/bseq_base_reg.sv
module bseq_base_reg #(
  parameter int unsigned ADDR_W = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] base_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     base_o <= '0;
    else if (load_i) base_o <= addr_i;
  end

  a_r2_base_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(base_o));
endmodule

// File: rtl/bseq_beat_ctr.sv
module bseq_beat_ctr #(
  parameter int unsigned OFS_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             adv_ni,
  output logic [OFS_W-1:0] beat_o
);
  localparam logic [OFS_W-1:0] LastBeat = {OFS_W{1'b1}};

  // load wins over advance
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      beat_o <= '0;
    else if (load_i)  beat_o <= '0;
    else if (!adv_ni) beat_o <= beat_o + 1'b1;
  end

  a_r5_load_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> beat_o == '0);
  a_r6_hold_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && adv_ni) |=> $stable(beat_o));
  a_r7_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !adv_ni && beat_o == LastBeat) |=> beat_o == '0);
endmodule

// File: rtl/bseq_offset_map.sv
module bseq_offset_map
  import bseq_pkg::*;
#(
  parameter int unsigned OFS_W = 2
) (
  input  logic [OFS_W-1:0] start_i,
  input  logic [OFS_W-1:0] beat_i,
  input  burst_order_e     order_i,
  output logic [OFS_W-1:0] ofs_o
);
  logic [OFS_W-1:0] xor_ofs, lin_ofs;

  assign xor_ofs = start_i ^ beat_i;
  assign lin_ofs = start_i + beat_i;  // wraps at burst length

  always_comb begin
    unique case (order_i)
      ORD_INTERLEAVE: ofs_o = xor_ofs;
      default:        ofs_o = lin_ofs;
    endcase
  end
endmodule

// File: rtl/bseq_burst_addr.sv
module bseq_burst_addr
  import bseq_pkg::*;
#(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned OFS_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              adv_ni,
  input  logic              interleave_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [OFS_W-1:0]  beat_o
);
  logic [ADDR_W-1:0] base_q;
  logic [OFS_W-1:0]  beat_q, ofs;
  burst_order_e      order;

  assign order = burst_order_e'(interleave_i);

  bseq_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk_i (clk_i), .rst_ni(rst_ni), .load_i(load_i),
    .addr_i(addr_i), .base_o(base_q)
  );

  bseq_beat_ctr #(.OFS_W(OFS_W)) u_beat (
    .clk_i (clk_i), .rst_ni(rst_ni), .load_i(load_i),
    .adv_ni(adv_ni), .beat_o(beat_q)
  );

  bseq_offset_map #(.OFS_W(OFS_W)) u_map (
    .start_i(base_q[OFS_W-1:0]), .beat_i(beat_q),
    .order_i(order), .ofs_o(ofs)
  );

  assign addr_o = {base_q[ADDR_W-1:OFS_W], ofs};
  assign beat_o = beat_q;

  a_r1_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> addr_o == $past(addr_i));
  a_r2_upper_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(addr_o[ADDR_W-1:OFS_W]));
  a_r6_hold_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && adv_ni && $stable(interleave_i)) |=> $stable(addr_o));
  a_r8_reset_value: assert property (@(posedge clk_i)
    !rst_ni |-> (addr_o == '0 && beat_o == '0));
endmodule

// File: tb/bseq_burst_addr_tb_top.sv
`timescale 1ns/1ps
module bseq_burst_addr_tb_top;
  localparam int ADDR_W = 17;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              load_i = 1'b0;
  logic              adv_ni = 1'b1;
  logic              interleave_i = 1'b1;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [ADDR_W-1:0] addr_o;
  logic [1:0]        beat_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [ADDR_W-1:0] m_base;
  int                m_beat;

  always #2.5 clk_i = ~clk_i;

  bseq_burst_addr #(.ADDR_W(ADDR_W), .OFS_W(2)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .adv_ni(adv_ni),
    .interleave_i(interleave_i), .addr_i(addr_i),
    .addr_o(addr_o), .beat_o(beat_o)
  );

  function automatic logic [ADDR_W-1:0] exp_addr(logic [ADDR_W-1:0] b, int bt, logic il);
    int s;
    int lo;
    s  = int'(b[1:0]);
    lo = il ? (s ^ bt) : ((s + bt) % 4);
    return {b[ADDR_W-1:2], 2'(lo)};
  endfunction

  task automatic check(string tag);
    logic [ADDR_W-1:0] ea;
    ea = exp_addr(m_base, m_beat, interleave_i);
    n_chk++;
    if (addr_o !== ea || beat_o !== 2'(m_beat)) begin
      n_bad++;
      $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
               tag, addr_o, beat_o, ea, m_beat);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    m_base = '0;
    m_beat = 0;
    addr_i = 17'h1ABCD;
    load_i = 1'b1;
    adv_ni = 1'b0;
    step();
    step();
    check("R8 reset");
    rst_ni = 1'b1;
    load_i = 1'b0;
    adv_ni = 1'b1;
    step();
    check("R8 after release");

    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        interleave_i = m[0];
        addr_i = {15'($urandom), 2'(s)};
        load_i = 1'b1;
        adv_ni = 1'b0;  // must be ignored
        step();
        m_base = addr_i;
        m_beat = 0;
        load_i = 1'b0;
        adv_ni = 1'b1;
        check("R1/R5 load");
        for (int k = 0; k < 6; k++) begin
          int holds;
          holds = int'($urandom % 3);
          for (int h = 0; h < holds; h++) begin
            adv_ni = 1'b1;
            step();
            check("R6 hold");
          end
          adv_ni = 1'b0;
          step();
          adv_ni = 1'b1;
          m_beat = (m_beat + 1) % 4;
          if (m_beat == 0) check("R7 wrap");
          else if (m == 1) check("R3 interleaved R2");
          else check("R4 linear R2");
        end
      end
    end

    // mid-burst reload with advance low
    interleave_i = 1'b0;
    addr_i = 17'h0F0F2;
    load_i = 1'b1;
    step();
    m_base = addr_i; m_beat = 0; load_i = 1'b0;
    adv_ni = 1'b0;
    step(); m_beat = 1;
    check("R4 linear from 10");
    addr_i = 17'h15553;
    load_i = 1'b1;
    adv_ni = 1'b0;
    step();
    m_base = addr_i; m_beat = 0;
    check("R5 mid-burst reload");
    load_i = 1'b0;
    step(); m_beat = 1;
    check("R7 step after reload");
    adv_ni = 1'b1;

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule